// File: doc/BRIEF.md
# Configuration Shadow Save Controller

This block holds a 48-byte live configuration file (offsets 00h to 2Fh) together with a non-volatile backing image of the same size. The image is kept inside the block as registers, cleared to factory defaults only by a power-on reset. A functional reset reloads the live file from the image. The bus side writes and reads the live file through a simple byte port.

Software starts a save by raising the save bit, bit 0 of byte 06h. The block then runs a busy window of a fixed number of cycles and copies the live file into the image when that window ends. A lock bit in the stored image freezes the image for good. Two control bits act only through their stored copies, and the power-down bit is never stored.

The decoded outputs are the busy flag, the stored lock state, the stored pin-mode bit and the live power-down bit. They feed the surrounding clock-control logic.

Top module: `cfg_shadow_store`

## Requirements
- R1: While por_n is low, the image takes the factory defaults. Every byte is 00h except these: byte 00h holds the ID_BYTE parameter (default 01h); 02h=B4h; 03h=01h; 05h=50h; 06h=60h. Within each 16-byte bank at 10h and 20h, the low offsets take these values: 4h=EDh; 5h=02h; 6h=01h; 7h=01h; 9h=40h; Ah=02h; Bh=08h; Dh=40h; Eh=02h; Fh=08h. While rst_n is low, the live file loads from the image. rst_n must stay low at least one cycle after por_n rises.
- R2: A write with wr_en high and busy low updates the live byte at wr_addr. Byte 00h never changes. In byte 01h, bits 7 and 6 ignore writes. Addresses 30h to 3Fh ignore writes and read 00h. rd_data is combinational from rd_addr.
- R3: A save starts only when byte 06h bit 0 changes from 0 to 1. Writing that bit as 1 again while it is already 1 starts nothing.
- R4: store_busy goes high on the clock edge after the edge that captured the rising save bit. It stays high for exactly SAVE_CYCLES cycles (default 64). While store_busy is high, byte 01h bit 6 reads 1; at all other times it reads 0.
- R5: While store_busy is high, bus writes are refused and leave the live file unchanged. Reads stay valid during that time.
- R6: When the busy window ends, the image takes the live contents, with these exceptions: byte 00h is kept; byte 01h bits 7, 6 and 4 are kept at 0; byte 06h bit 0 is kept at 0. The stored values are seen in the live file after the next rst_n.
- R7: lock_active equals the stored byte 01h bit 5. While it is 1, a rising save bit starts no busy window and the image never changes. Live writes still work.
- R8: pins_ctrl_mode equals the stored byte 02h bit 6, not the live bit.
- R9: power_down equals the live byte 01h bit 4. The stored copy of that bit is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, loads factory image |
| rst_n | input | 1 | Functional reset, active low, reloads live file from image |
| wr_en | input | 1 | Live byte write strobe |
| wr_addr | input | 6 | Live byte write offset |
| wr_data | input | 8 | Live byte write data |
| rd_addr | input | 6 | Read offset |
| rd_data | output | 8 | Read data (combinational) |
| store_busy | output | 1 | Save window in progress |
| lock_active | output | 1 | Stored lock bit |
| pins_ctrl_mode | output | 1 | Stored pin-mode bit |
| power_down | output | 1 | Live power-down bit |

## Verification
The hardest case to reach is the lock itself. The image stores a lock only through a complete save, and the effect of a stored lock is visible only after a later save request is ignored and a functional reset shows the old image again. The stimulus therefore goes in a fixed order. It first saves a pattern. It then saves the live lock bit. Next it changes a live byte and raises the save bit again. Finally it resets and compares every byte with the model image. Before the lock, a held-high save bit and writes made inside the busy window cover the edge-only start and the refusal rules.

// File: rtl/cfg_shadow_pkg.sv
package cfg_shadow_pkg;

   // factory default of one configuration byte
   function automatic logic [7:0] factory_byte(input int a, input logic [7:0] id);
      logic [7:0] v;
      v = 8'h00;
      if (a == 0)      v = id;
      else if (a == 2) v = 8'hB4;
      else if (a == 3) v = 8'h01;
      else if (a == 5) v = 8'h50;
      else if (a == 6) v = 8'h60;
      else if (a >= 16 && a < 48) begin
         case (a % 16)
            4:        v = 8'hED;
            5:        v = 8'h02;
            6, 7:     v = 8'h01;
            9, 13:    v = 8'h40;
            10, 14:   v = 8'h02;
            11, 15:   v = 8'h08;
            default:  v = 8'h00;
         endcase
      end
      return v;
   endfunction

   // bits the bus may change in the live file
   function automatic logic [7:0] live_wmask(input int a);
      if (a == 0)      return 8'h00;
      else if (a == 1) return 8'h3F;
      else             return 8'hFF;
   endfunction

   // bits a save copies into the image
   function automatic logic [7:0] store_mask(input int a);
      if (a == 0)      return 8'h00;
      else if (a == 1) return 8'h2F;
      else if (a == 6) return 8'hFE;
      else             return 8'hFF;
   endfunction

endpackage

// File: rtl/cfg_live_regs.sv
module cfg_live_regs #(
   parameter int NBYTES = 48,
   parameter int ADDR_W = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_ok,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [7:0]               wr_data,
   input  logic [NBYTES-1:0][7:0]   image,
   output logic [NBYTES-1:0][7:0]   live
);
   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      localparam logic [7:0] WMASK = cfg_shadow_pkg::live_wmask(b);
      always_ff @(posedge clk) begin
         if (!rst_n)
            live[b] <= image[b];
         else if (wr_ok && wr_addr == ADDR_W'(b))
            live[b] <= (live[b] & ~WMASK) | (wr_data & WMASK);
      end
   end
endmodule

// File: rtl/cfg_nv_image.sv
module cfg_nv_image #(
   parameter int          NBYTES  = 48,
   parameter logic [7:0]  ID_BYTE = 8'h01
) (
   input  logic                     clk,
   input  logic                     por_n,
   input  logic                     commit,
   input  logic [NBYTES-1:0][7:0]   live,
   output logic [NBYTES-1:0][7:0]   image
);
   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      localparam logic [7:0] DFLT  = cfg_shadow_pkg::factory_byte(b, ID_BYTE);
      localparam logic [7:0] SMASK = cfg_shadow_pkg::store_mask(b);
      always_ff @(posedge clk) begin
         if (!por_n)
            image[b] <= DFLT;
         else if (commit)
            image[b] <= (image[b] & ~SMASK) | (live[b] & SMASK);
      end
   end
endmodule

// File: rtl/cfg_save_seq.sv
module cfg_save_seq #(
   parameter int SAVE_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic save_bit,
   input  logic locked,
   output logic busy,
   output logic commit
);
   localparam int CW = $clog2(SAVE_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(SAVE_CYCLES - 1);

   logic          save_q;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         save_q <= 1'b0;
         busy   <= 1'b0;
         cnt    <= '0;
      end else begin
         save_q <= save_bit;
         if (busy) begin
            if (cnt == LAST) busy <= 1'b0;
            cnt <= cnt + 1'b1;
         end else if (save_bit && !save_q && !locked) begin
            busy <= 1'b1;
            cnt  <= '0;
         end
      end
   end

   assign commit = busy && (cnt == LAST);
endmodule

// File: rtl/cfg_shadow_store.sv
module cfg_shadow_store #(
   parameter int          NBYTES      = 48,
   parameter int          SAVE_CYCLES = 64,
   parameter logic [7:0]  ID_BYTE     = 8'h01
) (
   input  logic        clk,
   input  logic        por_n,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [5:0]  wr_addr,
   input  logic [7:0]  wr_data,
   input  logic [5:0]  rd_addr,
   output logic [7:0]  rd_data,
   output logic        store_busy,
   output logic        lock_active,
   output logic        pins_ctrl_mode,
   output logic        power_down
);
   localparam int ADDR_W = 6;

   if (NBYTES < 48 || NBYTES > (1 << ADDR_W)) begin : g_bad_nbytes
      $error("NBYTES must lie between 48 and 64");
   end
   if (SAVE_CYCLES < 1) begin : g_bad_cycles
      $error("SAVE_CYCLES must be at least 1");
   end

   logic [NBYTES-1:0][7:0] live_bytes;
   logic [NBYTES-1:0][7:0] img_bytes;
   logic                   commit;

   cfg_live_regs #(.NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_live (
      .clk(clk), .rst_n(rst_n), .wr_ok(wr_en && !store_busy),
      .wr_addr(wr_addr), .wr_data(wr_data),
      .image(img_bytes), .live(live_bytes));

   cfg_nv_image #(.NBYTES(NBYTES), .ID_BYTE(ID_BYTE)) u_image (
      .clk(clk), .por_n(por_n), .commit(commit),
      .live(live_bytes), .image(img_bytes));

   cfg_save_seq #(.SAVE_CYCLES(SAVE_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .save_bit(live_bytes[6][0]),
      .locked(img_bytes[1][5]), .busy(store_busy), .commit(commit));

   always_comb begin
      rd_data = 8'h00;
      if (int'(rd_addr) < NBYTES) begin
         rd_data = live_bytes[rd_addr];
         if (rd_addr == 6'd1) rd_data[6] = store_busy;
      end
   end

   assign lock_active    = img_bytes[1][5];
   assign pins_ctrl_mode = img_bytes[2][6];
   assign power_down     = live_bytes[1][4];
endmodule

// File: rtl/cfg_shadow_chk.sv
module cfg_shadow_chk #(
   parameter int NBYTES      = 48,
   parameter int SAVE_CYCLES = 64
) (
   input logic                    clk,
   input logic                    por_n,
   input logic                    rst_n,
   input logic                    busy,
   input logic                    lock,
   input logic [NBYTES-1:0][7:0]  live,
   input logic [NBYTES-1:0][7:0]  image
);
   int run;
   always_ff @(posedge clk) begin
      if (!rst_n)    run <= 0;
      else if (busy) run <= run + 1;
      else           run <= 0;
   end

   assert_busy_length_R4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      $fell(busy) |-> run == SAVE_CYCLES);

   assert_write_refused_R5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      busy |=> $stable(live));

   assert_image_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      lock |=> $stable(image));

   assert_no_start_locked_R7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      $rose(busy) |-> !$past(lock));

   assert_pdwn_not_stored_R9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      image[1][4] == 1'b0);
endmodule

bind cfg_shadow_store cfg_shadow_chk #(.NBYTES(NBYTES), .SAVE_CYCLES(SAVE_CYCLES)) i_chk (
   .clk(clk), .por_n(por_n), .rst_n(rst_n), .busy(store_busy),
   .lock(lock_active), .live(live_bytes), .image(img_bytes));

// File: tb/test_cfg_shadow_store.sv
module test_cfg_shadow_store;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 48;
   localparam int SAVE_N = 64;

   logic clk = 1'b0;
   logic por_n = 1'b0, rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [5:0] wr_addr = '0, rd_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic store_busy, lock_active, pins_ctrl_mode, power_down;

   int n_checks = 0, n_fail = 0, busy_run = 0;
   logic [7:0] exp_live [64];
   logic [7:0] exp_img  [64];

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_shadow_store i_cfg_shadow_store (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .store_busy(store_busy), .lock_active(lock_active),
      .pins_ctrl_mode(pins_ctrl_mode), .power_down(power_down));

   always @(posedge clk) begin
      #1;
      if (store_busy) busy_run++;
   end

   function automatic logic [7:0] dflt(input int a);
      int o;
      o = a % 16;
      if (a == 0) return 8'h01;
      if (a == 2) return 8'hB4;
      if (a == 3) return 8'h01;
      if (a == 5) return 8'h50;
      if (a == 6) return 8'h60;
      if (a < 16 || a >= NB) return 8'h00;
      if (o == 4) return 8'hED;
      if (o == 5) return 8'h02;
      if (o == 6 || o == 7) return 8'h01;
      if (o == 9 || o == 13) return 8'h40;
      if (o == 10 || o == 14) return 8'h02;
      if (o == 11 || o == 15) return 8'h08;
      return 8'h00;
   endfunction

   function automatic logic [7:0] wmask(input int a);
      return (a == 0) ? 8'h00 : (a == 1) ? 8'h3F : 8'hFF;
   endfunction

   function automatic logic [7:0] smask(input int a);
      return (a == 0) ? 8'h00 : (a == 1) ? 8'h2F : (a == 6) ? 8'hFE : 8'hFF;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [7:0] d, input bit refused);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
      if (!refused && a < NB) exp_live[a] = (exp_live[a] & ~wmask(a)) | (d & wmask(a));
   endtask

   task automatic rd_chk(input int a, input logic [7:0] exp, input string req);
      rd_addr = 6'(a);
      #1;
      chk(rd_data === exp, req, rd_data, exp);
   endtask

   task automatic check_all(input string req);
      for (int a = 0; a < 64; a++) rd_chk(a, (a < NB) ? exp_live[a] : 8'h00, req);
   endtask

   task automatic func_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      #1;
      for (int a = 0; a < NB; a++) exp_live[a] = exp_img[a];
   endtask

   // start a save with a clean 0->1 of the save bit and run it to the end
   task automatic do_save(input string req);
      int seen;
      wr(6, exp_live[6] & 8'hFE, 1'b0);
      wr(6, exp_live[6] | 8'h01, 1'b0);
      chk(store_busy === 1'b0, "R4 busy not before next edge", store_busy, 0);
      busy_run = 0;
      @(posedge clk); #2;
      chk(store_busy === 1'b1, req, store_busy, 1);
      rd_chk(1, exp_live[1] | 8'h40, "R4 status bit reads 1 while busy");
      wr(3, 8'hC3, 1'b1);
      rd_chk(3, exp_live[3], "R5 write refused during busy");
      seen = 0;
      while (store_busy && seen < 1000) begin @(posedge clk); #2; seen++; end
      chk(busy_run == SAVE_N, "R4 busy length", busy_run, SAVE_N);
      rd_chk(1, exp_live[1], "R4 status bit back to 0");
      for (int a = 0; a < NB; a++)
         exp_img[a] = (exp_img[a] & ~smask(a)) | (exp_live[a] & smask(a));
   endtask

   bit done = 1'b0;

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      for (int a = 0; a < 64; a++) begin exp_img[a] = dflt(a); exp_live[a] = dflt(a); end
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check_all("R1 factory defaults");
      chk(store_busy === 1'b0 && lock_active === 1'b0 && pins_ctrl_mode === 1'b0 && power_down === 1'b0,
          "R1 outputs after reset", {store_busy, lock_active, pins_ctrl_mode, power_down}, 0);

      // R2 pattern over every address including out of range
      for (int a = 0; a < 64; a++) begin
         logic [7:0] d;
         d = 8'((a * 29 + 11) ^ (a << 3));
         if (a == 6) d = d & 8'hFE;
         if (a == 1) d = 8'hC3;
         wr(a, d, 1'b0);
      end
      check_all("R2 pattern write and readback");

      // R8 live pin-mode bit has no effect; R9 power-down follows live bit
      wr(2, 8'hF4, 1'b0);
      chk(pins_ctrl_mode === 1'b0, "R8 live pin-mode ignored", pins_ctrl_mode, 0);
      wr(1, 8'h13, 1'b0);
      chk(power_down === 1'b1, "R9 power_down follows live bit", power_down, 1);
      rd_chk(1, 8'h13, "R2 byte 01h writable bits");

      // R3 R4 R5 first save
      do_save("R3 R4 save starts on rising save bit");
      chk(pins_ctrl_mode === 1'b1, "R8 stored pin-mode", pins_ctrl_mode, 1);
      chk(lock_active === 1'b0, "R7 not locked", lock_active, 0);

      // R3 held high: no new window
      wr(6, exp_live[6] | 8'h03, 1'b0);
      for (int i = 0; i < 4; i++) begin
         @(posedge clk); #2;
         chk(store_busy === 1'b0, "R3 held-high bit starts nothing", store_busy, 0);
      end

      // R6 change live, reset, expect image contents
      wr(10, 8'h77, 1'b0);
      wr(2, 8'h00, 1'b0);
      func_reset();
      check_all("R6 stored image reloaded");
      chk(power_down === 1'b0, "R9 power-down never stored", power_down, 0);
      chk(pins_ctrl_mode === 1'b1, "R8 stored bit kept", pins_ctrl_mode, 1);

      // R7 store the lock
      wr(1, 8'h20, 1'b0);
      chk(lock_active === 1'b0, "R7 live lock has no effect", lock_active, 0);
      do_save("R7 save storing the lock");
      chk(lock_active === 1'b1, "R7 lock stored", lock_active, 1);
      wr(3, 8'h5A, 1'b0);
      rd_chk(3, 8'h5A, "R7 live writes still work when locked");
      wr(6, 8'h00, 1'b0);
      wr(6, 8'h01, 1'b0);
      for (int i = 0; i < 4; i++) begin
         @(posedge clk); #2;
         chk(store_busy === 1'b0, "R7 locked save starts nothing", store_busy, 0);
      end
      func_reset();
      check_all("R7 image frozen after lock");
      rd_chk(3, exp_img[3], "R7 byte 03h kept old stored value");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule